// File: doc/BRIEF.md
# Dispatch Group Slot Accountant

This block keeps the books for an instruction scheduler that packs operations into fixed-size dispatch groups. Each accepted instruction arrives already classified: a slot-cost class, a record-form flag, a flag for operations that must lead a group, a branch flag and a small entry tag. On each issue strobe the block adds the instruction's cost to the running slot count. It opens a fresh group when the rules demand one and records the tag in a member list. A probe port tells a neighbouring hazard check whether a given tag is already in the open group.

For the candidate presented this cycle, the block also reports two values. The first is whether the scheduler should prefer another instruction, because this one would have to open a new group. The second is how many filler no-ops must be placed ahead of it when the hazard check flags a load-after-store conflict. The filler count depends on a mode bit that says whether a single group-terminating no-op is available. A no-op strobe records each filler that is actually emitted.

Group state is tracked by a four-state machine over the slot count: GRP_EMPTY (no slots used), GRP_OPEN (one to four slots), GRP_FIVE (exactly five) and GRP_SIX (six, reachable only by padding). The transitions are: open (GRP_EMPTY to GRP_OPEN on an issue), grow (an issue or a filler that stays in GRP_OPEN or reaches GRP_FIVE), restart (a leading-only instruction empties the group and starts it again), wrap (an issue in GRP_FIVE, or a second branch, returns to GRP_EMPTY), pad (a filler from GRP_FIVE to GRP_SIX) and close (a filler in terminating mode, or any filler in GRP_SIX, returns to GRP_EMPTY).

Top module: `dgrp_slot_acct`

## Requirements
- R1: A synchronous reset sets the slot count and branch count to zero and empties the member list, so that no probe tag hits.
- R2: Slot cost by class code: code 1 costs 2 slots, code 2 costs 4 slots, and codes 0 and 3 cost 1 slot. When a 1-slot class has the record-form flag set, it costs 2 slots.
- R3: An instruction is leading-only when its cost exceeds 1 or its leading flag is set. Issuing one while the slot count is nonzero first empties the group. The new slot count is then its cost, the branch count is its branch flag, and the member list holds only its tag.
- R4: An issue while the slot count is exactly 5 empties the group: the slot count and branch count become 0 and the member list is cleared. The instruction itself is not counted.
- R5: Issuing a branch while the branch count is 1 empties the group in the same way, without counting the branch.
- R6: With the hazard flag set, terminating mode on and a slot count below 6, the no-op count is 1.
- R7: In terminating mode off, the no-op count is 5 minus the slot count when the hazard flag is set and the slot count is below 6. It is 0 when the hazard flag is clear or the slot count is 6.
- R8: A no-op strobe empties the group when terminating mode is on or the slot count is 6. Otherwise it adds one slot and an empty member that never matches a probe.
- R9: The prefer-another output is 1 exactly when the presented candidate is leading-only (as defined in R3) and the slot count is nonzero.
- R10: When the issue and no-op strobes are high in the same cycle, only the issue takes effect.
- R11: The probe output is 1 when the probe tag equals the tag of an instruction issued into the current group.
- R12: Each branch added to a group raises the branch count by one. The branch count never exceeds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Issue strobe for the presented instruction |
| nop_emit_i | input | 1 | A filler no-op is emitted this cycle |
| cost_cls_i | input | 2 | Slot-cost class code of the candidate |
| record_form_i | input | 1 | Candidate is a record-form instruction |
| first_op_i | input | 1 | Candidate must lead a group regardless of cost |
| branch_i | input | 1 | Candidate is a branch |
| tag_i | input | TAG_W | Entry tag of the candidate |
| hazard_i | input | 1 | Load-after-store hazard flagged for the candidate |
| term_nop_i | input | 1 | A single group-terminating no-op is available |
| probe_tag_i | input | TAG_W | Tag to look up in the open group |
| slots_o | output | SLOT_W | Slots used in the open group |
| branches_o | output | 2 | Branches in the open group |
| prefer_other_o | output | 1 | Scheduler should pick a different candidate |
| nop_count_o | output | SLOT_W | Filler no-ops needed ahead of the candidate |
| probe_hit_o | output | 1 | Probe tag is a member of the open group |

## Verification
The slot count, branch count and member contents are registered. Their new values are due one clock edge after an issue or no-op strobe, so the bench drives each strobe just after a rising edge and reads these outputs just after the following edge. Prefer-another, the no-op count and the probe result are combinational functions of the registered state and the present inputs. The bench changes the candidate inputs mid-cycle and reads these outputs within the same cycle, with no edge in between.

// File: rtl/dgrp_pkg.sv
package dgrp_pkg;

    typedef enum logic [1:0] {
        GRP_EMPTY = 2'd0,
        GRP_OPEN  = 2'd1,
        GRP_FIVE  = 2'd2,
        GRP_SIX   = 2'd3
    } grp_state_t;

    typedef enum logic [1:0] {
        CLS_ONE  = 2'd0,
        CLS_TWO  = 2'd1,
        CLS_FOUR = 2'd2,
        CLS_ALT  = 2'd3
    } cost_cls_t;

endpackage

// File: rtl/dgrp_cost_dec.sv
module dgrp_cost_dec
    import dgrp_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic [1:0]        cls_i,
    input  logic              record_i,
    input  logic              lead_flag_i,
    output logic [SLOT_W-1:0] cost_o,
    output logic              lead_only_o
);
    always_comb begin
        unique case (cost_cls_t'(cls_i))
            CLS_TWO:  cost_o = SLOT_W'(2);
            CLS_FOUR: cost_o = SLOT_W'(4);
            default:  cost_o = SLOT_W'(1);
        endcase
        // R2: record forms of single-slot classes take a second slot
        if (cost_o == SLOT_W'(1) && record_i)
            cost_o = SLOT_W'(2);
        lead_only_o = (cost_o > SLOT_W'(1)) || lead_flag_i;
    end
endmodule

// File: rtl/dgrp_nop_calc.sv
module dgrp_nop_calc #(
    parameter int SLOT_W    = 3,
    parameter int LAST_SLOT = 5
) (
    input  logic [SLOT_W-1:0] slots_i,
    input  logic              hazard_i,
    input  logic              term_i,
    output logic [SLOT_W-1:0] nop_cnt_o
);
    localparam int FULL_SLOTS = LAST_SLOT + 1;

    always_comb begin
        nop_cnt_o = '0;
        if (hazard_i && slots_i < SLOT_W'(FULL_SLOTS)) begin
            if (term_i)
                nop_cnt_o = SLOT_W'(1);
            else
                nop_cnt_o = SLOT_W'(LAST_SLOT) - slots_i;
        end
    end
endmodule

// File: rtl/dgrp_member_list.sv
module dgrp_member_list #(
    parameter int DEPTH = 6,
    parameter int TAG_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clear_i,
    input  logic             push_i,
    input  logic             push_real_i,
    input  logic [TAG_W-1:0] push_tag_i,
    input  logic [TAG_W-1:0] probe_tag_i,
    output logic             probe_hit_o
);
    localparam int IDX_W = $clog2(DEPTH + 1);

    logic [IDX_W-1:0] count_q;
    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] hit_vec;
    logic [TAG_W-1:0] tag_q [DEPTH];

    // write slot: entry 0 after a clear, otherwise the next free entry
    logic [IDX_W-1:0] wr_idx;
    logic             wr_ok;

    assign wr_idx = (rst_i || clear_i) ? '0 : count_q;
    assign wr_ok  = push_i && (wr_idx < IDX_W'(DEPTH));

    always_ff @(posedge clk_i) begin
        if (rst_i)
            count_q <= '0;
        else if (clear_i)
            count_q <= push_i ? IDX_W'(1) : '0;
        else if (wr_ok)
            count_q <= count_q + IDX_W'(1);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
            end else if (wr_ok && wr_idx == IDX_W'(g)) begin
                valid_q[g] <= push_real_i;
                tag_q[g]   <= push_tag_i;
            end else if (clear_i) begin
                valid_q[g] <= 1'b0;
            end
        end
        assign hit_vec[g] = valid_q[g] && (tag_q[g] == probe_tag_i);
    end

    assign probe_hit_o = |hit_vec;
endmodule

// File: rtl/dgrp_slot_acct.sv
module dgrp_slot_acct
    import dgrp_pkg::*;
#(
    parameter int TAG_W        = 4,
    parameter int SLOT_W       = 3,
    parameter int LAST_SLOT    = 5,
    parameter int MEMBER_DEPTH = 6
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              issue_i,
    input  logic              nop_emit_i,
    input  logic [1:0]        cost_cls_i,
    input  logic              record_form_i,
    input  logic              first_op_i,
    input  logic              branch_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              hazard_i,
    input  logic              term_nop_i,
    input  logic [TAG_W-1:0]  probe_tag_i,
    output logic [SLOT_W-1:0] slots_o,
    output logic [1:0]        branches_o,
    output logic              prefer_other_o,
    output logic [SLOT_W-1:0] nop_count_o,
    output logic              probe_hit_o
);
    localparam int FULL_SLOTS = LAST_SLOT + 1;

    grp_state_t        state_q, state_d;
    logic [SLOT_W-1:0] slots_q, slots_d, base_slots, cost;
    logic [1:0]        br_q, br_d, base_br;
    logic              lead_only, grp_clear, push, push_real;

    dgrp_cost_dec #(.SLOT_W(SLOT_W)) i_cost (
        .cls_i       (cost_cls_i),
        .record_i    (record_form_i),
        .lead_flag_i (first_op_i),
        .cost_o      (cost),
        .lead_only_o (lead_only)
    );

    dgrp_nop_calc #(.SLOT_W(SLOT_W), .LAST_SLOT(LAST_SLOT)) i_nop (
        .slots_i   (slots_q),
        .hazard_i  (hazard_i),
        .term_i    (term_nop_i),
        .nop_cnt_o (nop_count_o)
    );

    dgrp_member_list #(.DEPTH(MEMBER_DEPTH), .TAG_W(TAG_W)) i_members (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .clear_i     (grp_clear),
        .push_i      (push),
        .push_real_i (push_real),
        .push_tag_i  (tag_i),
        .probe_tag_i (probe_tag_i),
        .probe_hit_o (probe_hit_o)
    );

    // transition logic: issue has priority over a filler strobe
    always_comb begin
        slots_d    = slots_q;
        br_d       = br_q;
        base_slots = slots_q;
        base_br    = br_q;
        grp_clear  = 1'b0;
        push       = 1'b0;
        push_real  = 1'b0;
        if (issue_i) begin
            if (state_q == GRP_FIVE || (branch_i && br_q == 2'd1)) begin
                // wrap
                slots_d   = '0;
                br_d      = '0;
                grp_clear = 1'b1;
            end else begin
                if (lead_only && state_q != GRP_EMPTY) begin
                    // restart
                    base_slots = '0;
                    base_br    = '0;
                    grp_clear  = 1'b1;
                end
                slots_d   = base_slots + cost;
                br_d      = base_br + {1'b0, branch_i};
                push      = 1'b1;
                push_real = 1'b1;
            end
        end else if (nop_emit_i) begin
            if (term_nop_i || state_q == GRP_SIX) begin
                // close
                slots_d   = '0;
                br_d      = '0;
                grp_clear = 1'b1;
            end else begin
                // pad / grow with an empty member
                slots_d = slots_q + SLOT_W'(1);
                push    = 1'b1;
            end
        end

        if (slots_d == '0)
            state_d = GRP_EMPTY;
        else if (slots_d == SLOT_W'(LAST_SLOT))
            state_d = GRP_FIVE;
        else if (slots_d == SLOT_W'(FULL_SLOTS))
            state_d = GRP_SIX;
        else
            state_d = GRP_OPEN;
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= GRP_EMPTY;
            slots_q <= '0;
            br_q    <= '0;
        end else begin
            state_q <= state_d;
            slots_q <= slots_d;
            br_q    <= br_d;
        end
    end

    // outputs
    always_comb begin
        slots_o    = slots_q;
        branches_o = br_q;
        unique case (state_q)
            GRP_EMPTY: prefer_other_o = 1'b0;
            GRP_OPEN,
            GRP_FIVE,
            GRP_SIX:   prefer_other_o = lead_only;
            default:   prefer_other_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dgrp_slot_acct_chk.sv
module dgrp_slot_acct_chk
    import dgrp_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              issue,
    input logic              nop_emit,
    input logic              branch,
    input logic              hazard,
    input logic              term,
    input logic [SLOT_W-1:0] slots,
    input logic [1:0]        branches,
    input logic              prefer,
    input logic [SLOT_W-1:0] nop_cnt,
    input grp_state_t        st
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (slots == '0 && branches == 2'd0));

    // R4
    five_state_chk: assert property (@(posedge clk) disable iff (rst)
        (st == GRP_FIVE) == (slots == SLOT_W'(5)));

    // R4
    five_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && st == GRP_FIVE) |=> (slots == '0));

    // R5
    branch_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && branch && branches == 2'd1) |=> (slots == '0 && branches == 2'd0));

    // R6
    term_nop_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (hazard && term && slots < SLOT_W'(6)) |-> (nop_cnt == SLOT_W'(1)));

    // R8
    nop_close_chk: assert property (@(posedge clk) disable iff (rst)
        (!issue && nop_emit && term) |=> (slots == '0));

    // R9
    prefer_chk: assert property (@(posedge clk) disable iff (rst)
        prefer |-> (slots != '0));

    // R10
    priority_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && nop_emit && st != GRP_FIVE && !(branch && branches == 2'd1))
        |=> (slots != '0));

    // R12
    branch_bound_chk: assert property (@(posedge clk) disable iff (rst)
        branches <= 2'd1);
endmodule

bind dgrp_slot_acct dgrp_slot_acct_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk      (clk_i),
    .rst      (rst_i),
    .issue    (issue_i),
    .nop_emit (nop_emit_i),
    .branch   (branch_i),
    .hazard   (hazard_i),
    .term     (term_nop_i),
    .slots    (slots_o),
    .branches (branches_o),
    .prefer   (prefer_other_o),
    .nop_cnt  (nop_count_o),
    .st       (state_q)
);

// File: tb/test_dgrp_slot_acct.sv
`timescale 1ns/1ps
module test_dgrp_slot_acct;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       issue = 0, nop_emit = 0, rec = 0, fo = 0, br = 0, haz = 0, term = 0;
    logic [1:0] cls = 0;
    logic [3:0] tag = 0, probe = 0;
    logic [2:0] slots, nopc;
    logic [1:0] brs;
    logic       pref, hit;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    dgrp_slot_acct i_dgrp_slot_acct (
        .clk_i(clk), .rst_i(rst), .issue_i(issue), .nop_emit_i(nop_emit),
        .cost_cls_i(cls), .record_form_i(rec), .first_op_i(fo), .branch_i(br),
        .tag_i(tag), .hazard_i(haz), .term_nop_i(term), .probe_tag_i(probe),
        .slots_o(slots), .branches_o(brs), .prefer_other_o(pref),
        .nop_count_o(nopc), .probe_hit_o(hit)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_issue(input int c, input bit r, input bit f, input bit b, input int t);
        cls = 2'(c); rec = r; fo = f; br = b; tag = 4'(t); issue = 1;
        @(posedge clk); #1;
        issue = 0; rec = 0; fo = 0; br = 0; cls = 0;
    endtask

    task automatic do_nop(input bit t);
        term = t; nop_emit = 1;
        @(posedge clk); #1;
        nop_emit = 0; term = 0;
    endtask

    task automatic look(input int t, input int exp, input string req);
        probe = 4'(t); #0.5;
        chk(req, int'(hit), exp);
    endtask

    task automatic t_reset();
        chk("R1 slots", int'(slots), 0);
        chk("R1 branches", int'(brs), 0);
        look(0, 0, "R1 probe");
    endtask

    task automatic t_costs();
        do_issue(0, 0, 0, 0, 1); chk("R2 class0", int'(slots), 1); do_nop(1);
        do_issue(0, 1, 0, 0, 1); chk("R2 record", int'(slots), 2); do_nop(1);
        do_issue(1, 0, 0, 0, 1); chk("R2 class1", int'(slots), 2); do_nop(1);
        do_issue(2, 0, 0, 0, 1); chk("R2 class2", int'(slots), 4); do_nop(1);
        do_issue(3, 0, 0, 0, 1); chk("R2 class3", int'(slots), 1); do_nop(1);
        chk("R8 close", int'(slots), 0);
    endtask

    task automatic t_restart();
        cls = 2; #0.5; chk("R9 empty", int'(pref), 0); cls = 0;
        do_issue(0, 0, 0, 0, 1);
        cls = 0; fo = 0; #0.5; chk("R9 plain", int'(pref), 0);
        fo = 1; #0.5; chk("R9 lead flag", int'(pref), 1);
        fo = 0; cls = 2; #0.5; chk("R9 cost4", int'(pref), 1);
        cls = 0; rec = 1; #0.5; chk("R9 record", int'(pref), 1); rec = 0;
        look(1, 1, "R11 member");
        do_issue(1, 0, 0, 0, 2);
        chk("R3 slots", int'(slots), 2);
        look(2, 1, "R3 new tag");
        look(1, 0, "R3 old tag gone");
        do_issue(0, 0, 1, 0, 3);
        chk("R3 flag restart", int'(slots), 1);
        do_nop(1);
    endtask

    task automatic t_five();
        do_issue(2, 0, 0, 0, 4);
        do_issue(0, 0, 0, 0, 5);
        chk("R4 at five", int'(slots), 5);
        look(5, 1, "R11 second member");
        do_issue(0, 0, 0, 0, 6);
        chk("R4 wrap", int'(slots), 0);
        look(6, 0, "R4 not added");
        look(4, 0, "R4 cleared");
    endtask

    task automatic t_branch();
        do_issue(0, 0, 0, 1, 7);
        chk("R12 one branch", int'(brs), 1);
        do_issue(0, 0, 0, 0, 9);
        chk("R12 kept", int'(brs), 1);
        chk("R12 slots", int'(slots), 2);
        do_issue(0, 0, 0, 1, 8);
        chk("R5 slots", int'(slots), 0);
        chk("R5 branches", int'(brs), 0);
        look(8, 0, "R5 not added");
    endtask

    task automatic t_nops();
        haz = 1; #0.5; chk("R7 empty", int'(nopc), 5);
        haz = 0;
        do_issue(0, 0, 0, 0, 1); do_issue(0, 0, 0, 0, 2); do_issue(0, 0, 0, 0, 3);
        haz = 1; term = 0; #0.5; chk("R7 at three", int'(nopc), 2);
        term = 1; #0.5; chk("R6 at three", int'(nopc), 1);
        haz = 0; #0.5; chk("R7 no hazard", int'(nopc), 0);
        term = 0;
        do_nop(0); chk("R8 grow", int'(slots), 4);
        look(0, 0, "R8 empty member");
        do_nop(0); chk("R8 to five", int'(slots), 5);
        haz = 1; #0.5; chk("R7 at five", int'(nopc), 0);
        haz = 0;
        do_nop(0); chk("R8 pad six", int'(slots), 6);
        haz = 1; term = 1; #0.5; chk("R6 at six", int'(nopc), 0);
        term = 0; #0.5; chk("R7 at six", int'(nopc), 0);
        haz = 0;
        do_nop(0); chk("R8 close six", int'(slots), 0);
    endtask

    task automatic t_priority();
        term = 1; nop_emit = 1;
        do_issue(0, 0, 0, 0, 9);
        nop_emit = 0; term = 0;
        chk("R10 slots", int'(slots), 1);
        look(9, 1, "R10 member");
        do_nop(1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_costs();
        t_restart();
        t_five();
        t_branch();
        t_nops();
        t_priority();
        rst = 1; @(posedge clk); #1 rst = 0;
        chk("R1 late reset", int'(slots), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule